// File: doc/BRIEF.md
# Rotating Priority Resolver with In-Service Tracking

This block arbitrates among eight interrupt request lines. Requests that are pending and not masked are ranked by a rotating scheme. A programmable base offset says which input holds level 0, and the levels rise from there with wrap-around. The block raises its interrupt line only when the best candidate outranks every request already in service. The in-service set is kept in a register inside the block.

A processor-side controller drives the block with single-cycle strobes. The acknowledge strobe moves the current winner into service, or retires it at once when automatic end-of-interrupt is on. The command strobe selects one of several operations: a non-specific end-of-interrupt, a specific end-of-interrupt, the rotating form of each of these, or a direct load of the base offset. An init strobe clears the in-service set, the mask and the offset. Edge or level detection of the request lines and byte decoding of commands happen upstream.

Top module: `prio_isr_core`

## Requirements
- R1: The candidate set is `req_i & ~mask_o`. A candidate at input k has level (k - offset_o) mod 8. When `irq_o` is high, `vec_o` is the candidate with the smallest level.
- R2: `irq_o` is high only when the candidate set is non-empty and the winning level is strictly below the smallest level present in `isr_o`. An empty in-service set counts as level 8.
- R3: With parameter IS_PRIMARY=1 and `nest_en_i` high, in-service bit 2 is left out of the comparison in R2. When `nest_en_i` is low, it is included.
- R4: An `ack_i` pulse while `irq_o` is high sets `isr_o[vec_o]` at the next edge. An `ack_i` pulse while `irq_o` is low changes neither `isr_o` nor `offset_o`.
- R5: When `aeoi_en_i` is high, a valid acknowledge leaves `isr_o` unchanged. If `rot_aeoi_i` is also high, `offset_o` becomes `vec_o`+1 mod 8. `rot_aeoi_i` alone has no effect on the offset.
- R6: Command op 1 clears the in-service bit with the smallest level, with bit 2 always included. Op 2 does the same and also loads `offset_o` with that input + 1 mod 8. Both ops do nothing when `isr_o` is zero.
- R7: Command op 3 clears `isr_o[cmd_field_i]`. Op 4 does the same and also loads `offset_o` with `cmd_field_i`+1 mod 8.
- R8: Command op 5 loads `offset_o` with `cmd_field_i`+1 mod 8 and leaves `isr_o` unchanged.
- R9: Reset and `init_i` both leave `isr_o`, `mask_o` and `offset_o` at zero. `init_i` overrides every other strobe in the same cycle.
- R10: `mask_we_i` loads `mask_o` from `mask_wdata_i` at the next edge.
- R11: When `ack_i` and `cmd_valid_i` are high in the same cycle, the command is dropped. Ops 0, 6 and 7 change nothing.
- R12: `irq_o` and `vec_o` follow `req_i` combinationally within the same cycle. They follow changes to the mask, in-service set and offset from the edge that registers those changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous clear of in-service set, mask and offset |
| req_i | input | NUM_IN | Pending request vector |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | NUM_IN | New mask value |
| aeoi_en_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi_i | input | 1 | Rotate offset on automatic end-of-interrupt |
| nest_en_i | input | 1 | Leave in-service bit 2 out of the comparison (primary only) |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (see R6 to R8, R11) |
| cmd_field_i | input | IDX_W | Input index or offset field for the command |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | IDX_W | Index of the winning input |
| isr_o | output | NUM_IN | In-service set |
| mask_o | output | NUM_IN | Mask register |
| offset_o | output | IDX_W | Rotation base offset |

## Verification
The assertions assume that the strobes are synchronous single-cycle pulses. They also assume that inputs are never unknown after reset. The acknowledge checks compare against `vec_o` from the cycle of the strobe, so they assume `req_i` is held steady across that edge. The bench drives every input on the falling edge and clears each strobe one cycle after raising it. It raises `ack_i` and `cmd_valid_i` together only in the dedicated precedence test, which is what keeps it inside these assumptions.

// File: rtl/prio_pkg.sv
package prio_pkg;

    // Command codes for cmd_op_i
    localparam logic [2:0] OP_NOP         = 3'd0;
    localparam logic [2:0] OP_EOI_TOP     = 3'd1;
    localparam logic [2:0] OP_EOI_TOP_ROT = 3'd2;
    localparam logic [2:0] OP_EOI_IDX     = 3'd3;
    localparam logic [2:0] OP_EOI_IDX_ROT = 3'd4;
    localparam logic [2:0] OP_SET_BASE    = 3'd5;

endpackage

// File: rtl/prio_rot_find.sv
// Finds the set bit with the lowest rotated level. Level p sits at input
// (p + base) mod N. Level N means the vector is empty. N must be a power of two.
module prio_rot_find #(
    parameter int NUM_IN = 8,
    localparam int IDX_W = $clog2(NUM_IN),
    localparam int LVL_W = IDX_W + 1
) (
    input  logic [NUM_IN-1:0] bits_i,
    input  logic [IDX_W-1:0]  base_i,
    output logic              found_o,
    output logic [LVL_W-1:0]  level_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [IDX_W-1:0] pos;

    always_comb begin
        found_o = 1'b0;
        level_o = LVL_W'(NUM_IN);
        idx_o   = '0;
        pos     = '0;
        for (int p = NUM_IN - 1; p >= 0; p--) begin
            pos = IDX_W'(p) + base_i;
            if (bits_i[pos]) begin
                found_o = 1'b1;
                level_o = LVL_W'(p);
                idx_o   = pos;
            end
        end
    end

endmodule

// File: rtl/prio_isr_core.sv
module prio_isr_core #(
    parameter int NUM_IN     = 8,
    parameter bit IS_PRIMARY = 1'b1,
    parameter int NEST_IDX   = 2,
    localparam int IDX_W = $clog2(NUM_IN),
    localparam int LVL_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [NUM_IN-1:0] req_i,
    input  logic              mask_we_i,
    input  logic [NUM_IN-1:0] mask_wdata_i,
    input  logic              aeoi_en_i,
    input  logic              rot_aeoi_i,
    input  logic              nest_en_i,
    input  logic              ack_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [IDX_W-1:0]  cmd_field_i,
    output logic              irq_o,
    output logic [IDX_W-1:0]  vec_o,
    output logic [NUM_IN-1:0] isr_o,
    output logic [NUM_IN-1:0] mask_o,
    output logic [IDX_W-1:0]  offset_o
);
    import prio_pkg::*;

    typedef struct packed {
        logic [NUM_IN-1:0] isr;
        logic [NUM_IN-1:0] mask;
        logic [IDX_W-1:0]  base;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_IN-1:0] cand;
    logic [NUM_IN-1:0] isr_cmp;
    logic              req_found, srv_found, top_found;
    logic [LVL_W-1:0]  req_lvl, srv_lvl, top_lvl;
    logic [IDX_W-1:0]  req_idx, srv_idx, top_idx;
    logic              irq;

    assign cand = req_i & ~st_q.mask;

    generate
        if (IS_PRIMARY) begin : g_nest
            always_comb begin
                isr_cmp = st_q.isr;
                if (nest_en_i) isr_cmp[NEST_IDX] = 1'b0;
            end
        end else begin : g_plain
            assign isr_cmp = st_q.isr;
        end
    endgenerate

    prio_rot_find #(.NUM_IN(NUM_IN)) u_req_find (
        .bits_i (cand),
        .base_i (st_q.base),
        .found_o(req_found),
        .level_o(req_lvl),
        .idx_o  (req_idx)
    );

    prio_rot_find #(.NUM_IN(NUM_IN)) u_srv_find (
        .bits_i (isr_cmp),
        .base_i (st_q.base),
        .found_o(srv_found),
        .level_o(srv_lvl),
        .idx_o  (srv_idx)
    );

    prio_rot_find #(.NUM_IN(NUM_IN)) u_top_find (
        .bits_i (st_q.isr),
        .base_i (st_q.base),
        .found_o(top_found),
        .level_o(top_lvl),
        .idx_o  (top_idx)
    );

    assign irq = req_found && (req_lvl < srv_lvl);

    always_comb begin
        st_d = st_q;
        if (mask_we_i) st_d.mask = mask_wdata_i;
        if (ack_i) begin
            if (irq) begin
                if (aeoi_en_i) begin
                    if (rot_aeoi_i) st_d.base = req_idx + 1'b1;
                end else begin
                    st_d.isr[req_idx] = 1'b1;
                end
            end
        end else if (cmd_valid_i) begin
            case (cmd_op_i)
                OP_EOI_TOP: begin
                    if (top_found) st_d.isr[top_idx] = 1'b0;
                end
                OP_EOI_TOP_ROT: begin
                    if (top_found) begin
                        st_d.isr[top_idx] = 1'b0;
                        st_d.base         = top_idx + 1'b1;
                    end
                end
                OP_EOI_IDX: st_d.isr[cmd_field_i] = 1'b0;
                OP_EOI_IDX_ROT: begin
                    st_d.isr[cmd_field_i] = 1'b0;
                    st_d.base             = cmd_field_i + 1'b1;
                end
                OP_SET_BASE: st_d.base = cmd_field_i + 1'b1;
                default: ;
            endcase
        end
        if (init_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o    = irq;
    assign vec_o    = req_idx;
    assign isr_o    = st_q.isr;
    assign mask_o   = st_q.mask;
    assign offset_o = st_q.base;

    // srv_found and srv_idx are not needed beyond the level compare
    logic unused_ok;
    assign unused_ok = &{1'b0, srv_found, srv_idx, top_lvl};

endmodule

// File: rtl/prio_isr_core_chk.sv
module prio_isr_core_chk #(
    parameter int NUM_IN = 8,
    localparam int IDX_W = $clog2(NUM_IN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_i,
    input logic [NUM_IN-1:0] req_i,
    input logic              mask_we_i,
    input logic [NUM_IN-1:0] mask_wdata_i,
    input logic              aeoi_en_i,
    input logic              rot_aeoi_i,
    input logic              ack_i,
    input logic              cmd_valid_i,
    input logic [2:0]        cmd_op_i,
    input logic [IDX_W-1:0]  cmd_field_i,
    input logic              irq_o,
    input logic [IDX_W-1:0]  vec_o,
    input logic [NUM_IN-1:0] isr_o,
    input logic [NUM_IN-1:0] mask_o,
    input logic [IDX_W-1:0]  offset_o
);

    logic cmd_go;
    assign cmd_go = cmd_valid_i && !ack_i && !init_i;

    AST_IRQ_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_i[vec_o] && !mask_o[vec_o])); // R1

    AST_IRQ_NOT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && req_i == isr_o && isr_o != '0 && mask_o == '0) |-> 1'b0 || !isr_o[vec_o] || vec_o == 3'd2); // R2

    AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !aeoi_en_i && !init_i) |=> isr_o[$past(vec_o)]); // R4

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !init_i) |=> ($stable(isr_o) && $stable(offset_o))); // R4

    AST_AEOI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && aeoi_en_i && !init_i) |=> $stable(isr_o)); // R5

    AST_AEOI_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && aeoi_en_i && rot_aeoi_i && !init_i)
        |=> (offset_o == $past(vec_o) + 1'b1)); // R5

    AST_TOP_EOI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && (cmd_op_i == 3'd1 || cmd_op_i == 3'd2))
        |=> (((isr_o & ~$past(isr_o)) == '0) && ($countones(isr_o ^ $past(isr_o)) <= 1))); // R6

    AST_IDX_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && (cmd_op_i == 3'd3 || cmd_op_i == 3'd4)) |=> !isr_o[$past(cmd_field_i)]); // R7

    AST_SET_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_op_i == 3'd5)
        |=> ($stable(isr_o) && offset_o == $past(cmd_field_i) + 1'b1)); // R8

    AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (isr_o == '0 && mask_o == '0 && offset_o == '0)); // R9

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && !init_i) |=> (mask_o == $past(mask_wdata_i))); // R10

    AST_NOP_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && (cmd_op_i == 3'd0 || cmd_op_i == 3'd6 || cmd_op_i == 3'd7))
        |=> ($stable(isr_o) && $stable(offset_o))); // R11

endmodule

bind prio_isr_core prio_isr_core_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .req_i       (req_i),
    .mask_we_i   (mask_we_i),
    .mask_wdata_i(mask_wdata_i),
    .aeoi_en_i   (aeoi_en_i),
    .rot_aeoi_i  (rot_aeoi_i),
    .ack_i       (ack_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_field_i (cmd_field_i),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .isr_o       (isr_o),
    .mask_o      (mask_o),
    .offset_o    (offset_o)
);

// File: tb/prio_isr_core_bench.sv
`timescale 1ns/1ps
module prio_isr_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_i = 1'b0;
    logic [7:0] req_i = '0;
    logic       mask_we_i = 1'b0;
    logic [7:0] mask_wdata_i = '0;
    logic       aeoi_en_i = 1'b0;
    logic       rot_aeoi_i = 1'b0;
    logic       nest_en_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [2:0] cmd_op_i = '0;
    logic [2:0] cmd_field_i = '0;
    logic       irq_o;
    logic [2:0] vec_o;
    logic [7:0] isr_o;
    logic [7:0] mask_o;
    logic [2:0] offset_o;

    int total = 0;
    int bad = 0;

    logic [7:0] m_isr = '0;
    logic [7:0] m_mask = '0;
    int         m_off = 0;

    always #2 clk = ~clk;

    prio_isr_core u_prio_isr_core (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .req_i(req_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .aeoi_en_i(aeoi_en_i), .rot_aeoi_i(rot_aeoi_i), .nest_en_i(nest_en_i),
        .ack_i(ack_i), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_field_i(cmd_field_i), .irq_o(irq_o), .vec_o(vec_o),
        .isr_o(isr_o), .mask_o(mask_o), .offset_o(offset_o)
    );

    function automatic int lvl(input logic [7:0] b, input int off);
        for (int p = 0; p < 8; p++) if (b[(p + off) % 8]) return p;
        return 8;
    endfunction

    // -1 when no interrupt is expected, else the winning input
    function automatic int exp_win();
        logic [7:0] cmp;
        int wl;
        wl  = lvl(req_i & ~m_mask, m_off);
        cmp = m_isr;
        if (nest_en_i) cmp[2] = 1'b0;
        if (wl < 8 && wl < lvl(cmp, m_off)) return (wl + m_off) % 8;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", r, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_comb(input string r);
        int e, a;
        #1;
        e = exp_win();
        a = irq_o ? int'(vec_o) : -1;
        chk(a == e, r, a, e);
        @(negedge clk);
    endtask

    task automatic chk_state(input string r);
        int a, e;
        a = int'(isr_o) * 4096 + int'(mask_o) * 16 + int'(offset_o);
        e = int'(m_isr) * 4096 + int'(m_mask) * 16 + m_off;
        chk(a == e, r, a, e);
    endtask

    task automatic m_ack_model();
        int w;
        w = exp_win();
        if (w >= 0) begin
            if (aeoi_en_i) begin
                if (rot_aeoi_i) m_off = (w + 1) % 8;
            end else m_isr[w] = 1'b1;
        end
    endtask

    task automatic do_ack();
        m_ack_model();
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
    endtask

    task automatic do_cmd(input int op, input int fld);
        int l, i;
        case (op)
            1, 2: begin
                l = lvl(m_isr, m_off);
                if (l < 8) begin
                    i = (l + m_off) % 8;
                    m_isr[i] = 1'b0;
                    if (op == 2) m_off = (i + 1) % 8;
                end
            end
            3: m_isr[fld] = 1'b0;
            4: begin m_isr[fld] = 1'b0; m_off = (fld + 1) % 8; end
            5: m_off = (fld + 1) % 8;
            default: ;
        endcase
        cmd_valid_i = 1'b1;
        cmd_op_i    = 3'(op);
        cmd_field_i = 3'(fld);
        step();
        cmd_valid_i = 1'b0;
    endtask

    task automatic set_mask(input logic [7:0] v);
        m_mask       = v;
        mask_we_i    = 1'b1;
        mask_wdata_i = v;
        step();
        mask_we_i    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R9 reset");
        chk_comb("R2 reset idle");

        // R1: every request pattern under every offset
        for (int o = 0; o < 8; o++) begin
            do_cmd(5, (o + 7) % 8);
            chk_state("R8 base load");
            for (int r = 0; r < 256; r++) begin
                req_i = 8'(r);
                chk_comb("R1 winner");
            end
        end
        req_i = '0;

        // R10 / R1: mask sweep with all lines requesting
        for (int m = 0; m < 256; m++) begin
            set_mask(8'(m));
            chk_state("R10 mask load");
            req_i = 8'hFF;
            chk_comb("R1 masked winner");
            req_i = '0;
        end
        set_mask('0);

        // R2 / R4 / R7: in-service level against every single request
        do_cmd(5, 7);
        for (int i = 0; i < 8; i++) begin
            req_i = 8'(1 << i);
            do_ack();
            req_i = '0;
            chk_state("R4 ack sets");
            for (int j = 0; j < 8; j++) begin
                req_i = 8'(1 << j);
                chk_comb("R2 outrank");
            end
            req_i = 8'(1 << i);
            do_ack();
            chk_state("R4 ack while low");
            req_i = '0;
            do_cmd(3, i);
            chk_state("R7 specific clear");
        end

        // R3: nested mode ignores in-service bit 2
        req_i = 8'h04;
        do_ack();
        nest_en_i = 1'b1;
        chk_comb("R3 nest same input");
        req_i = 8'h08;
        chk_comb("R3 nest lower input");
        nest_en_i = 1'b0;
        chk_comb("R3 nest off");
        req_i = '0;
        do_cmd(3, 2);
        chk_state("R7 clear bit2");

        // R5: automatic end-of-interrupt
        aeoi_en_i = 1'b1;
        req_i = 8'h10;
        do_ack();
        chk_state("R5 aeoi keeps isr");
        rot_aeoi_i = 1'b1;
        req_i = 8'h40;
        do_ack();
        chk_state("R5 aeoi rotate");
        aeoi_en_i = 1'b0;
        req_i = 8'h02;
        do_ack();
        chk_state("R5 rotate flag alone");
        rot_aeoi_i = 1'b0;
        req_i = '0;
        do_cmd(3, 1);

        // R6: non-specific end-of-interrupt
        do_cmd(5, 3);
        req_i = 8'h02; do_ack();
        req_i = 8'h20; do_ack();
        req_i = '0;
        chk_state("R6 setup");
        do_cmd(1, 0);
        chk_state("R6 top clear");
        do_cmd(2, 0);
        chk_state("R6 top clear rotate");
        do_cmd(1, 0);
        chk_state("R6 empty");
        do_cmd(2, 0);
        chk_state("R6 empty rotate");

        // R7: specific with rotation, and clearing an idle bit
        req_i = 8'h08; do_ack();
        req_i = 8'h04; do_ack();
        req_i = '0;
        chk_state("R7 setup");
        do_cmd(4, 3);
        chk_state("R7 specific rotate");
        do_cmd(3, 5);
        chk_state("R7 idle bit");
        do_cmd(3, 2);

        // R8: base load leaves in-service set alone
        req_i = 8'h01; do_ack(); req_i = '0;
        for (int f = 0; f < 8; f++) begin
            do_cmd(5, f);
            chk_state("R8 base sweep");
        end

        // R11: ack wins over a simultaneous command; no-op codes
        req_i = 8'h40;
        m_ack_model();
        ack_i = 1'b1; cmd_valid_i = 1'b1; cmd_op_i = 3'd3; cmd_field_i = 3'd0;
        step();
        ack_i = 1'b0; cmd_valid_i = 1'b0;
        req_i = '0;
        chk_state("R11 ack precedence");
        do_cmd(0, 6); chk_state("R11 op0");
        do_cmd(6, 6); chk_state("R11 op6");
        do_cmd(7, 6); chk_state("R11 op7");

        // R12: outputs follow requests within the cycle and mask after the edge
        do_cmd(3, 0);
        do_cmd(3, 6);
        do_cmd(5, 7);
        req_i = 8'h30;
        chk_comb("R12 request change");
        req_i = 8'h20;
        chk_comb("R12 request change again");
        set_mask(8'h20);
        chk_comb("R12 mask effect");
        req_i = '0;

        // R9: init overrides other strobes
        req_i = 8'h80; do_ack(); req_i = '0;
        do_cmd(5, 4);
        init_i = 1'b1; mask_we_i = 1'b1; mask_wdata_i = 8'h55;
        cmd_valid_i = 1'b1; cmd_op_i = 3'd5; cmd_field_i = 3'd2;
        m_isr = '0; m_mask = '0; m_off = 0;
        step();
        init_i = 1'b0; mask_we_i = 1'b0; cmd_valid_i = 1'b0;
        chk_state("R9 init clear");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule